// File: doc/BRIEF.md
# Mailbox Register-Access Bridge

This block gives a host access to a remote register space with 24-bit addresses through two narrow ports. A bidirectional transfer port carries everything: the host writes a command word, then a data word if the command is a write. It later reads back a status word, plus a data word if the command was a read. A read-only status port carries a ready bit that tells the host a response is waiting, and a sticky overrun bit.

After the command is accepted, or the data word for a write, the bridge waits a configurable number of cycles. It then performs the access on an internal register bank and queues the response words. Ready stays high until the host has read every queued word. Reading the transfer port while ready is low returns zero and changes nothing, so a host can flush any stale response by reading until ready drops. Any write to the transfer port while an access is in flight or a response is pending is dropped and raises the overrun bit.

Top module: `mbx_bridge`

## Requirements
- R1: After reset the status port reads 0, the transfer port reads 0, and every remote register reads back as 0.
- R2: A command word with bits [31:24] = 0x01 reads the register at address bits [23:0]. Its response is two words: the status word 0x00000000 first, then the register contents.
- R3: A command word with bits [31:24] = 0x10 waits for one further data word on the transfer port. Only then does the access start; until then ready stays 0. The access stores the data word at the address in bits [23:0]. Its response is one status word, 0x00000000.
- R4: Ready is 0 from the cycle after the accepting edge until exactly LATENCY clock edges later. It rises after that edge. The accepting edge is the read command edge or the write data edge.
- R5: Ready stays 1 until the last response word has been read. It drops right after the edge that reads that word, and not before.
- R6: Any other opcode gives a single status word 0x00000001 (error code in the low byte) and leaves the registers unchanged.
- R7: An address of NUM_REGS or above gives status 0x00000002. A read then returns data word 0. A write still consumes its data word but stores nothing.
- R8: A transfer-port write made while an access is in flight or a response is pending is ignored. It sets status bit 1, which stays set until reset. The pending response is not altered.
- R9: Transfer-port reads while ready is 0 return 0 and have no effect on the bridge.
- R10: Status port bit 0 is ready, bit 1 is overrun, and bits [31:2] read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_wr_en | input | 1 | Host write strobe for the transfer port |
| xfer_wr_data | input | 32 | Command or write data word |
| xfer_rd_en | input | 1 | Host read strobe for the transfer port; pops one response word when ready |
| xfer_rd_data | output | 32 | Head response word while ready, else 0 |
| stat_rd_data | output | 32 | Status port: bit 0 ready, bit 1 sticky overrun |

## Verification
Two things can coincide on the transfer port in one cycle. The host's read that drains the last response word can arrive on the same edge as a write of a new command. The bench issues both strobes together on the final word. The drained word must still match, and the command must be treated as an overrun, not started. Ready must stay low for longer than the access latency afterwards, and overrun must be set. A second collision is a command written while the access is still counting down. That command must be dropped without disturbing the response that follows.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 24;

    localparam logic [7:0] OP_READ  = 8'h01;
    localparam logic [7:0] OP_WRITE = 8'h10;

    localparam logic [7:0] ERR_NONE   = 8'h00;
    localparam logic [7:0] ERR_OPCODE = 8'h01;
    localparam logic [7:0] ERR_RANGE  = 8'h02;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DATA,
        ST_BUSY,
        ST_RESP
    } mbx_state_e;

    typedef enum logic [1:0] {
        ACC_RD,
        ACC_WR,
        ACC_BAD
    } acc_kind_e;
endpackage

// File: rtl/mbx_cmd_decode.sv
module mbx_cmd_decode
    import mbx_pkg::*;
#(
    parameter int NUM_REGS = 16,
    localparam int IDX_W = $clog2(NUM_REGS)
) (
    input  logic [WORD_W-1:0] cmd_word,
    output acc_kind_e         kind,
    output logic [IDX_W-1:0]  idx,
    output logic              in_range
);
    logic [7:0]        opcode;
    logic [ADDR_W-1:0] addr;

    assign opcode   = cmd_word[31:24];
    assign addr     = cmd_word[ADDR_W-1:0];
    assign idx      = addr[IDX_W-1:0];
    assign in_range = (addr < ADDR_W'(NUM_REGS));

    always_comb begin
        case (opcode)
            OP_READ:  kind = ACC_RD;
            OP_WRITE: kind = ACC_WR;
            default:  kind = ACC_BAD;
        endcase
    end
endmodule

// File: rtl/mbx_regbank.sv
module mbx_regbank #(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] regs_q [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[i] <= '0;
            end else if (we && widx == IDX_W'(i)) begin
                regs_q[i] <= wdata;
            end
        end
    end

    assign rdata = regs_q[ridx];
endmodule

// File: rtl/mbx_resp_q.sv
module mbx_resp_q #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 2,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_n,
    input  logic [DATA_W-1:0] load_w0,
    input  logic [DATA_W-1:0] load_w1,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count
);
    logic [DATA_W-1:0] ent_d [DEPTH];
    logic [DATA_W-1:0] ent_q [DEPTH];
    logic [CNT_W-1:0]  count_d, count_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_comb begin
            ent_d[i] = ent_q[i];
            if (load) begin
                if (i == 0)      ent_d[i] = load_w0;
                else if (i == 1) ent_d[i] = load_w1;
                else             ent_d[i] = '0;
            end else if (pop) begin
                if (i < DEPTH - 1) ent_d[i] = ent_q[(i + 1) % DEPTH];
                else               ent_d[i] = '0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ent_q[i] <= '0;
            else        ent_q[i] <= ent_d[i];
        end
    end

    always_comb begin
        count_d = count_q;
        if (load)                     count_d = load_n;
        else if (pop && count_q != 0) count_d = count_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign head  = ent_q[0];
    assign count = count_q;
endmodule

// File: rtl/mbx_bridge.sv
module mbx_bridge
    import mbx_pkg::*;
#(
    parameter int NUM_REGS = 16,
    parameter int LATENCY  = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        xfer_wr_en,
    input  logic [31:0] xfer_wr_data,
    input  logic        xfer_rd_en,
    output logic [31:0] xfer_rd_data,
    output logic [31:0] stat_rd_data
);
    localparam int IDX_W = $clog2(NUM_REGS);
    localparam int LAT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;
    localparam int QCW   = $clog2(3);

    typedef struct packed {
        mbx_state_e        st;
        logic [LAT_W-1:0]  cnt;
        acc_kind_e         kind;
        logic              in_range;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] wdata;
        logic              ovr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    acc_kind_e         dec_kind;
    logic [IDX_W-1:0]  dec_idx;
    logic              dec_in_range;
    logic              bank_we;
    logic [WORD_W-1:0] bank_rdata;
    logic              q_load;
    logic [QCW-1:0]    q_load_n;
    logic [WORD_W-1:0] q_w0, q_w1, q_head;
    logic [QCW-1:0]    q_count;
    logic              q_pop;
    logic              ready;
    mbx_state_e        st_q;

    mbx_cmd_decode #(.NUM_REGS(NUM_REGS)) u_dec (
        .cmd_word (xfer_wr_data),
        .kind     (dec_kind),
        .idx      (dec_idx),
        .in_range (dec_in_range)
    );

    mbx_regbank #(.NUM_REGS(NUM_REGS), .DATA_W(WORD_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bank_we),
        .widx  (ctl_q.idx),
        .wdata (ctl_q.wdata),
        .ridx  (ctl_q.idx),
        .rdata (bank_rdata)
    );

    mbx_resp_q #(.DATA_W(WORD_W), .DEPTH(2)) u_respq (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (q_load),
        .load_n  (q_load_n),
        .load_w0 (q_w0),
        .load_w1 (q_w1),
        .pop     (q_pop),
        .head    (q_head),
        .count   (q_count)
    );

    assign ready = (ctl_q.st == ST_RESP);
    assign q_pop = xfer_rd_en && ready;
    assign st_q  = ctl_q.st;

    always_comb begin
        ctl_d    = ctl_q;
        q_load   = 1'b0;
        q_load_n = '0;
        q_w0     = '0;
        q_w1     = '0;
        bank_we  = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (xfer_wr_en) begin
                    ctl_d.kind     = dec_kind;
                    ctl_d.idx      = dec_idx;
                    ctl_d.in_range = dec_in_range;
                    ctl_d.wdata    = '0;
                    if (dec_kind == ACC_WR) begin
                        ctl_d.st = ST_DATA;
                    end else begin
                        ctl_d.st  = ST_BUSY;
                        ctl_d.cnt = LAT_W'(LATENCY - 1);
                    end
                end
            end
            ST_DATA: begin
                if (xfer_wr_en) begin
                    ctl_d.wdata = xfer_wr_data;
                    ctl_d.st    = ST_BUSY;
                    ctl_d.cnt   = LAT_W'(LATENCY - 1);
                end
            end
            ST_BUSY: begin
                if (xfer_wr_en) ctl_d.ovr = 1'b1;
                if (ctl_q.cnt == '0) begin
                    q_load   = 1'b1;
                    ctl_d.st = ST_RESP;
                    case (ctl_q.kind)
                        ACC_RD: begin
                            q_load_n = QCW'(2);
                            q_w0 = {24'd0, ctl_q.in_range ? ERR_NONE : ERR_RANGE};
                            q_w1 = ctl_q.in_range ? bank_rdata : '0;
                        end
                        ACC_WR: begin
                            q_load_n = QCW'(1);
                            q_w0     = {24'd0, ctl_q.in_range ? ERR_NONE : ERR_RANGE};
                            bank_we  = ctl_q.in_range;
                        end
                        default: begin
                            q_load_n = QCW'(1);
                            q_w0     = {24'd0, ERR_OPCODE};
                        end
                    endcase
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            ST_RESP: begin
                if (xfer_wr_en) ctl_d.ovr = 1'b1;
                if (q_pop && q_count == QCW'(1)) ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, kind: ACC_BAD, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign xfer_rd_data = ready ? q_head : '0;
    assign stat_rd_data = {30'd0, ctl_q.ovr, ready};
endmodule

// File: rtl/mbx_bridge_chk.sv
module mbx_bridge_chk
    import mbx_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        xfer_wr_en,
    input logic        xfer_rd_en,
    input logic [31:0] stat_rd_data,
    input mbx_state_e  st
);
    assert_ready_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_rd_data[0]) |-> $past(st) == ST_BUSY);

    assert_accept_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_rd_data[0] && xfer_wr_en && st != ST_BUSY) |=> !stat_rd_data[0]);

    assert_ready_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd_data[0] && !xfer_rd_en) |=> stat_rd_data[0]);

    assert_ready_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_rd_data[0]) |-> $past(xfer_rd_en));

    assert_ovr_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_wr_en && (st == ST_BUSY || st == ST_RESP)) |=> stat_rd_data[1]);

    assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd_data[1] |=> stat_rd_data[1]);

    assert_flush_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && xfer_rd_en && !xfer_wr_en) |=> st == ST_IDLE);
endmodule

bind mbx_bridge mbx_bridge_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .xfer_wr_en   (xfer_wr_en),
    .xfer_rd_en   (xfer_rd_en),
    .stat_rd_data (stat_rd_data),
    .st           (st_q)
);

// File: tb/mbx_bridge_tb_top.sv
module mbx_bridge_tb_top;
    localparam int LAT  = 3;
    localparam int NREG = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic [31:0] stat;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    mbx_bridge #(.NUM_REGS(NREG), .LATENCY(LAT)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .xfer_wr_en   (wr_en),
        .xfer_wr_data (wr_data),
        .xfer_rd_en   (rd_en),
        .xfer_rd_data (rd_data),
        .stat_rd_data (stat)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic expect_word(logic [31:0] w, string tag);
        exp_q.push_back(w);
        tag_q.push_back(tag);
    endtask

    // monitor: compares each drained word against the scoreboard
    always @(negedge clk) begin
        if (rst_n && rd_en) begin
            if (stat[0]) begin
                if (exp_q.size() == 0) begin
                    n_cmp++;
                    n_bad++;
                    $display("FAIL R5 unexpected response: actual %h expected none", rd_data);
                end else begin
                    check(tag_q.pop_front(), rd_data, exp_q.pop_front());
                end
            end else begin
                check("R9 read while not ready", rd_data, 32'h0);
            end
        end
    end

    task automatic push_wr(logic [31:0] d);
        @(posedge clk); #2;
        wr_en = 1'b1; wr_data = d;
        @(posedge clk); #2;
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pull();
        @(posedge clk); #2;
        rd_en = 1'b1;
        @(posedge clk); #2;
        rd_en = 1'b0;
    endtask

    task automatic pull_and_push(logic [31:0] d);
        @(posedge clk); #2;
        rd_en = 1'b1; wr_en = 1'b1; wr_data = d;
        @(posedge clk); #2;
        rd_en = 1'b0; wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic lat_chk(string tag);
        for (int k = 0; k <= LAT; k++) begin
            @(negedge clk);
            check(tag, {31'd0, stat[0]}, (k == LAT) ? 32'd1 : 32'd0);
        end
    endtask

    task automatic wait_ready();
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (stat[0]) break;
        end
    endtask

    task automatic read_reg(int idx, logic [31:0] data, logic [7:0] code, string tag);
        expect_word({24'd0, code}, tag);
        expect_word(data, tag);
        push_wr({8'h01, 24'(idx)});
        lat_chk("R4 read latency");
        pull();
        check("R5 ready held between words", {31'd0, stat[0]}, 32'd1);
        pull();
        check("R5 ready drops after last word", {31'd0, stat[0]}, 32'd0);
    endtask

    task automatic write_reg(logic [23:0] addr, logic [31:0] data, logic [7:0] code, string tag);
        expect_word({24'd0, code}, tag);
        push_wr({8'h10, addr});
        for (int k = 0; k < 4; k++) @(negedge clk);
        check("R3 waits for data word", {31'd0, stat[0]}, 32'd0);
        push_wr(data);
        lat_chk("R4 write latency");
        pull();
        check("R5 ready drops after status word", {31'd0, stat[0]}, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R5 watchdog: actual hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check("R1 status after reset", stat, 32'h0);
        check("R1 transfer port after reset", rd_data, 32'h0);

        read_reg(5, 32'h0, 8'h00, "R1 R2 reset register read");
        write_reg(24'h3, 32'hDEADBEEF, 8'h00, "R3 write status");
        read_reg(3, 32'hDEADBEEF, 8'h00, "R2 read back");
        write_reg(24'hF, 32'h12345678, 8'h00, "R3 top register write");
        read_reg(15, 32'h12345678, 8'h00, "R2 top register read");

        // R6: unknown opcode, single status word, no register change
        expect_word(32'h1, "R6 bad opcode status");
        push_wr(32'h7F000003);
        lat_chk("R4 bad opcode latency");
        pull();
        check("R6 single word response", {31'd0, stat[0]}, 32'd0);
        read_reg(3, 32'hDEADBEEF, 8'h00, "R6 register unchanged");

        // R7: out-of-range addresses
        read_reg(16, 32'h0, 8'h02, "R7 range read");
        write_reg(24'hFFFFFF, 32'h0000AAAA, 8'h02, "R7 range write");
        read_reg(15, 32'h12345678, 8'h00, "R7 no aliased write");
        check("R10 no overrun yet", stat, 32'h0);

        // R8: command during the in-flight access
        expect_word(32'h0, "R8 response kept");
        expect_word(32'hDEADBEEF, "R8 response kept");
        push_wr(32'h01000003);
        push_wr(32'h10000004);
        wait_ready();
        check("R8 R10 overrun and ready", stat, 32'h3);
        pull();
        pull();
        check("R8 overrun sticky after drain", stat, 32'h2);
        read_reg(4, 32'h0, 8'h00, "R8 dropped command had no effect");

        // R8: last drain and new command in the same cycle
        expect_word(32'h0, "R8 collision status");
        expect_word(32'h12345678, "R8 collision data");
        push_wr(32'h0100000F);
        wait_ready();
        pull();
        pull_and_push(32'h01000003);
        begin
            int seen = 0;
            for (int k = 0; k < LAT + 4; k++) begin
                @(negedge clk);
                if (stat[0]) seen++;
            end
            check("R8 colliding command ignored", 32'(seen), 32'd0);
        end
        check("R8 overrun still set", stat, 32'h2);

        // R9: reads while idle, then flush a pending response
        pull();
        pull();
        check("R9 idle reads leave status", stat, 32'h2);
        read_reg(3, 32'hDEADBEEF, 8'h00, "R9 normal access after idle reads");
        expect_word(32'h0, "R9 flush status");
        expect_word(32'h12345678, "R9 flush data");
        push_wr(32'h0100000F);
        wait_ready();
        for (int k = 0; k < 4; k++) begin
            if (!stat[0]) break;
            pull();
            @(negedge clk);
        end
        check("R9 flushed", stat, 32'h2);
        check("R5 scoreboard drained", 32'(exp_q.size()), 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule